// File: doc/BRIEF.md
# Sixteen-bit ALU with status and control flag word

The block adds, subtracts and combines two 16-bit operands, at word or byte width, and keeps a 16-bit flag word next to the datapath. The result is combinational. The six status flags that describe the result are written into the flag word on the clock edge only when the update enable is high. Add-with-carry and subtract-with-borrow take their carry input from the stored carry flag.

Three control flags sit in the same word: direction, interrupt enable and trap. A separate command input sets or clears each one, and it may act in the same cycle as a status update. Seven bits of the word are not assigned. They read as a fixed pattern.

Top module: `alu_flag_unit`

## Requirements
- R1: After a clock edge with `rst_n` low, `flag_word` reads 16'h0002: all nine defined flags are 0, bit 1 is 1, and the other unused bits are 0.
- R2: `op_sel` codes are 0 add, 1 add with carry (a+b+CF), 2 subtract, 3 subtract with borrow (a-b-CF), 4 AND, 5 OR, 6 XOR. For codes 0 to 3, `result` is the arithmetic value modulo 2^width, where CF is the stored flag bit 0.
- R3: For AND, OR and XOR, the status captured sets CF, OF and AF to 0, and sets SF, ZF and PF from the result.
- R4: With `byte_mode`=1, codes 0 to 6 use only bits 7:0 of the operands, `result[15:8]` is 0, and the carry, overflow and sign flags use bit 7 as the most significant bit.
- R5: CF (bit 0) is the carry out of the most significant bit for addition, and the borrow for subtraction (a < b + borrow in, unsigned).
- R6: OF (bit 11) is 1 exactly when the signed result of an add or subtract lies outside the signed range of the selected width.
- R7: SF (bit 7) copies the most significant result bit at the selected width. ZF (bit 6) is 1 exactly when the result at that width is zero.
- R8: AF (bit 4) is the carry out of bit 3 for addition, and the borrow into bit 3 for subtraction, with the carry or borrow input included.
- R9: PF (bit 2) is 1 when `result[7:0]` holds an even number of one bits, also for word operations.
- R10: On a clock edge with `upd_en`=1 and `op_sel`≠7, flag bits 0, 2, 4, 6, 7 and 11 take the values above. Otherwise those bits keep their value.
- R11: `ctl_cmd` codes are 1 clear DF, 2 set DF (bit 10), 3 clear IF, 4 set IF (bit 9), 5 clear TF, 6 set TF (bit 8). Codes 0 and 7 do nothing. A command acts on the clock edge, and it acts in the same edge as a status update without disturbing it.
- R12: `op_sel`=7 passes `op_a` to `result` at full width and never changes the status flags, even with `upd_en`=1.
- R13: The unused bits 1, 3, 5 and 15:12 hold their fixed values (bit 1 one, the rest zero) under every operation and command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| op_sel | input | 3 | Operation code |
| byte_mode | input | 1 | 1 selects 8-bit width |
| upd_en | input | 1 | Capture status flags at the clock edge |
| ctl_cmd | input | 3 | Control flag set or clear command |
| result | output | 16 | Combinational result |
| flag_word | output | 16 | Registered flag word |

## Verification
Two things can land on the same clock edge: a status capture from the datapath and a set or clear of a control flag. Both write the one flag word. A second overlap is an add-with-carry or subtract-with-borrow that reads the stored carry flag while that same flag is being rewritten. Random stimulus drives `upd_en` and `ctl_cmd` independently, directed cycles pair each command with a flag-changing update, and chains of carry-using operations run back to back. After every edge, the full flag word is compared with a bench model that merges both effects, and each result is compared against the carry stored at the previous edge.

// File: rtl/alu_flag_pkg.sv
// Package: shared encodings, flag bit positions and the status bundle
// for the ALU flag unit. Assumes a 16-bit flag word.
package alu_flag_pkg;

    localparam int FLAG_W = 16;

    localparam int POS_CF   = 0;
    localparam int POS_PF   = 2;
    localparam int POS_AF   = 4;
    localparam int POS_ZF   = 6;
    localparam int POS_SF   = 7;
    localparam int POS_TF   = 8;
    localparam int POS_IF   = 9;
    localparam int POS_DF   = 10;
    localparam int POS_OF   = 11;

    // value read on bits that carry no flag
    localparam logic [FLAG_W-1:0] FLAG_FIXED = 16'h0002;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADC  = 3'd1,
        OP_SUB  = 3'd2,
        OP_SBB  = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_XOR  = 3'd6,
        OP_PASS = 3'd7
    } alu_op_e;

    typedef enum logic [2:0] {
        CC_NONE     = 3'd0,
        CC_CLR_DIR  = 3'd1,
        CC_SET_DIR  = 3'd2,
        CC_CLR_INT  = 3'd3,
        CC_SET_INT  = 3'd4,
        CC_CLR_TRAP = 3'd5,
        CC_SET_TRAP = 3'd6,
        CC_NONE_ALT = 3'd7
    } ctl_cmd_e;

    typedef struct packed {
        logic cf;
        logic pf;
        logic af;
        logic zf;
        logic sf;
        logic of;
    } status_t;

endpackage

// File: rtl/alu_datapath.sv
// Module: combinational adder and logic unit. Produces the result plus
// the raw carry terms needed for flags. Byte mode works on the low half
// and zeroes the high half. Assumes DATA_W is even and at least 8.
module alu_datapath
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  alu_op_e           op,
    input  logic              byte_mode,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              is_arith,
    output logic              is_sub,
    output logic              carry_out,
    output logic              nibble_carry,
    output logic              msb_a,
    output logic              msb_b
);
    localparam int HALF = DATA_W / 2;

    logic              use_c;
    logic              cin;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   sum_w;
    logic [HALF:0]     sum_b;
    logic [4:0]        sum_n;
    logic [DATA_W-1:0] logic_r;

    // operand conditioning: subtraction is a + ~b + ~borrow
    always_comb begin
        is_arith = (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) || (op == OP_SBB);
        is_sub   = (op == OP_SUB) || (op == OP_SBB);
        use_c    = (op == OP_ADC) || (op == OP_SBB);
        b_eff    = is_sub ? ~b : b;
        cin      = (use_c & carry_in) ^ is_sub;
    end

    // adders at word, byte and nibble width
    always_comb begin
        sum_w = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
        sum_b = {1'b0, a[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]} + {{HALF{1'b0}}, cin};
        sum_n = {1'b0, a[3:0]} + {1'b0, b_eff[3:0]} + {4'b0, cin};
    end

    // bitwise operations and final result select
    always_comb begin
        case (op)
            OP_AND:  logic_r = a & b;
            OP_OR:   logic_r = a | b;
            OP_XOR:  logic_r = a ^ b;
            default: logic_r = '0;
        endcase
        if (op == OP_PASS) begin
            result = a;
        end else if (is_arith) begin
            result = byte_mode ? {{(DATA_W-HALF){1'b0}}, sum_b[HALF-1:0]} : sum_w[DATA_W-1:0];
        end else begin
            result = byte_mode ? {{(DATA_W-HALF){1'b0}}, logic_r[HALF-1:0]} : logic_r;
        end
    end

    // width-dependent carry and sign sources for the flag logic
    always_comb begin
        carry_out    = byte_mode ? sum_b[HALF] : sum_w[DATA_W];
        nibble_carry = sum_n[4];
        msb_a        = byte_mode ? a[HALF-1] : a[DATA_W-1];
        msb_b        = byte_mode ? b_eff[HALF-1] : b_eff[DATA_W-1];
    end

endmodule

// File: rtl/alu_status_gen.sv
// Module: derives the six status flags from the result and the adder
// carry terms. Bitwise operations force carry, overflow and nibble
// carry low. Parity always looks at the low eight result bits.
module alu_status_gen
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] result,
    input  logic              byte_mode,
    input  logic              is_arith,
    input  logic              is_sub,
    input  logic              carry_out,
    input  logic              nibble_carry,
    input  logic              msb_a,
    input  logic              msb_b,
    output status_t           st
);
    localparam int HALF = DATA_W / 2;

    logic msb_r;
    logic [DATA_W-1:0] width_mask;

    // flag equations; borrow is the inverted adder carry
    always_comb begin
        width_mask = byte_mode ? {{(DATA_W-HALF){1'b0}}, {HALF{1'b1}}} : {DATA_W{1'b1}};
        msb_r      = byte_mode ? result[HALF-1] : result[DATA_W-1];
        st.cf      = is_arith & (carry_out ^ is_sub);
        st.af      = is_arith & (nibble_carry ^ is_sub);
        st.of      = is_arith & (msb_a == msb_b) & (msb_r != msb_a);
        st.sf      = msb_r;
        st.zf      = ((result & width_mask) == '0);
        st.pf      = ~(^result[7:0]);
    end

endmodule

// File: rtl/alu_flag_reg.sv
// Module: registered flag word. Status bits load on st_load; control
// bits follow set/clear commands in the same edge. Unused bits are
// constant. Synchronous active-low reset.
module alu_flag_reg
    import alu_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_load,
    input  status_t           st_in,
    input  ctl_cmd_e          cmd,
    output logic [FLAG_W-1:0] flag_word
);
    status_t status_q;
    logic    dir_q;
    logic    int_q;
    logic    trap_q;

    // status flag capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (st_load) begin
            status_q <= st_in;
        end
    end

    // control flag set and clear commands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            int_q  <= 1'b0;
            trap_q <= 1'b0;
        end else begin
            case (cmd)
                CC_CLR_DIR:  dir_q  <= 1'b0;
                CC_SET_DIR:  dir_q  <= 1'b1;
                CC_CLR_INT:  int_q  <= 1'b0;
                CC_SET_INT:  int_q  <= 1'b1;
                CC_CLR_TRAP: trap_q <= 1'b0;
                CC_SET_TRAP: trap_q <= 1'b1;
                default: ;
            endcase
        end
    end

    // assemble the readable word
    always_comb begin
        flag_word         = FLAG_FIXED;
        flag_word[POS_CF] = status_q.cf;
        flag_word[POS_PF] = status_q.pf;
        flag_word[POS_AF] = status_q.af;
        flag_word[POS_ZF] = status_q.zf;
        flag_word[POS_SF] = status_q.sf;
        flag_word[POS_OF] = status_q.of;
        flag_word[POS_TF] = trap_q;
        flag_word[POS_IF] = int_q;
        flag_word[POS_DF] = dir_q;
    end

    a_r10_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_load && (cmd == CC_NONE || cmd == CC_NONE_ALT)) |=> $stable(flag_word));

    a_r11_set_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CC_SET_DIR) |=> flag_word[POS_DF]);

    a_r11_clr_int: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CC_CLR_INT) |=> !flag_word[POS_IF]);

    a_r11_set_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CC_SET_TRAP) |=> flag_word[POS_TF]);

endmodule

// File: rtl/alu_flag_unit.sv
// Module: top of the ALU flag unit. Combinational datapath feeding a
// registered flag word; the stored carry flag is the carry input for
// add-with-carry and subtract-with-borrow.
module alu_flag_unit
    import alu_flag_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [2:0]        op_sel,
    input  logic              byte_mode,
    input  logic              upd_en,
    input  logic [2:0]        ctl_cmd,
    output logic [DATA_W-1:0] result,
    output logic [FLAG_W-1:0] flag_word
);
    localparam int HALF = DATA_W / 2;

    alu_op_e  op;
    ctl_cmd_e cmd;
    logic     is_arith, is_sub, carry_out, nibble_carry, msb_a, msb_b;
    logic     st_load;
    status_t  st;

    // decode of the raw select inputs
    always_comb begin
        op      = alu_op_e'(op_sel);
        cmd     = ctl_cmd_e'(ctl_cmd);
        st_load = upd_en && (op != OP_PASS);
    end

    alu_datapath #(.DATA_W(DATA_W)) u_path (
        .a            (op_a),
        .b            (op_b),
        .op           (op),
        .byte_mode    (byte_mode),
        .carry_in     (flag_word[POS_CF]),
        .result       (result),
        .is_arith     (is_arith),
        .is_sub       (is_sub),
        .carry_out    (carry_out),
        .nibble_carry (nibble_carry),
        .msb_a        (msb_a),
        .msb_b        (msb_b)
    );

    alu_status_gen #(.DATA_W(DATA_W)) u_stat (
        .result       (result),
        .byte_mode    (byte_mode),
        .is_arith     (is_arith),
        .is_sub       (is_sub),
        .carry_out    (carry_out),
        .nibble_carry (nibble_carry),
        .msb_a        (msb_a),
        .msb_b        (msb_b),
        .st           (st)
    );

    alu_flag_reg u_freg (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_load   (st_load),
        .st_in     (st),
        .cmd       (cmd),
        .flag_word (flag_word)
    );

    a_r10_status_load: assert property (@(posedge clk) disable iff (!rst_n)
        st_load |=> (flag_word[POS_CF] == $past(st.cf)) && (flag_word[POS_ZF] == $past(st.zf))
                 && (flag_word[POS_OF] == $past(st.of)) && (flag_word[POS_PF] == $past(st.pf)));

    a_r12_pass_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == 3'd7) |=> $stable({flag_word[POS_OF], flag_word[POS_SF], flag_word[POS_ZF],
                                      flag_word[POS_AF], flag_word[POS_PF], flag_word[POS_CF]}));

    a_r4_byte_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_mode && op_sel != 3'd7) |-> (result[DATA_W-1:HALF] == '0));

    a_r3_logic_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && (op_sel == 3'd4 || op_sel == 3'd5 || op_sel == 3'd6))
        |=> (!flag_word[POS_CF] && !flag_word[POS_OF] && !flag_word[POS_AF]));

endmodule

// File: tb/alu_flag_unit_tb.sv
module alu_flag_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = '0, op_b = '0;
    logic [2:0]  op_sel = '0;
    logic        byte_mode = 1'b0, upd_en = 1'b0;
    logic [2:0]  ctl_cmd = '0;
    logic [15:0] result, flag_word;

    int checks = 0;
    int failures = 0;
    logic [15:0] expf;

    always #2 clk = ~clk;

    alu_flag_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
        .byte_mode(byte_mode), .upd_en(upd_en), .ctl_cmd(ctl_cmd),
        .result(result), .flag_word(flag_word)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // returns {result, cf, pf, af, zf, sf, of}
    function automatic logic [21:0] model(input logic [15:0] a, input logic [15:0] b,
                                          input logic [2:0] op, input logic bm, input logic cfi);
        int w, mask, ua, ub, sa, sb, cin, full, sres, r;
        logic c, o, h, zf, sf, pf;
        logic [15:0] rv;
        w    = bm ? 8 : 16;
        mask = (1 << w) - 1;
        ua   = int'(a) & mask;
        ub   = int'(b) & mask;
        sa   = (ua >= (1 << (w-1))) ? ua - (1 << w) : ua;
        sb   = (ub >= (1 << (w-1))) ? ub - (1 << w) : ub;
        cin  = (op == 3'd1 || op == 3'd3) ? int'(cfi) : 0;
        c = 1'b0; o = 1'b0; h = 1'b0; sres = 0; full = 0;
        case (op)
            3'd0, 3'd1: begin
                full = ua + ub + cin;
                r    = full & mask;
                c    = full > mask;
                h    = ((ua & 15) + (ub & 15) + cin) > 15;
                sres = sa + sb + cin;
                o    = (sres > ((1 << (w-1)) - 1)) || (sres < -(1 << (w-1)));
            end
            3'd2, 3'd3: begin
                full = ua - ub - cin;
                r    = full & mask;
                c    = full < 0;
                h    = ((ua & 15) - (ub & 15) - cin) < 0;
                sres = sa - sb - cin;
                o    = (sres > ((1 << (w-1)) - 1)) || (sres < -(1 << (w-1)));
            end
            3'd4: r = ua & ub;
            3'd5: r = ua | ub;
            3'd6: r = ua ^ ub;
            default: r = int'(a);
        endcase
        rv = r[15:0];
        zf = ((r & mask) == 0);
        sf = bm ? rv[7] : rv[15];
        pf = ~(^rv[7:0]);
        return {rv, c, pf, h, zf, sf, o};
    endfunction

    // one operation: check result before the edge, flag word after it
    task automatic step(input string tag, input logic [15:0] a, input logic [15:0] b,
                        input logic [2:0] op, input logic bm, input logic upd, input logic [2:0] cmd);
        logic [21:0] m;
        @(negedge clk);
        op_a = a; op_b = b; op_sel = op; byte_mode = bm; upd_en = upd; ctl_cmd = cmd;
        #1;
        m = model(a, b, op, bm, expf[0]);
        chk({tag, " result"}, result, m[21:6]);
        if (upd && op != 3'd7) begin
            expf[0]  = m[5];
            expf[2]  = m[4];
            expf[4]  = m[3];
            expf[6]  = m[2];
            expf[7]  = m[1];
            expf[11] = m[0];
        end
        case (cmd)
            3'd1: expf[10] = 1'b0;
            3'd2: expf[10] = 1'b1;
            3'd3: expf[9]  = 1'b0;
            3'd4: expf[9]  = 1'b1;
            3'd5: expf[8]  = 1'b0;
            3'd6: expf[8]  = 1'b1;
            default: ;
        endcase
        @(posedge clk);
        #1;
        chk({tag, " flags"}, flag_word, expf);
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset word", flag_word, 16'h0002);
        expf = 16'h0002;
        @(negedge clk);
        rst_n = 1'b1;

        // directed corner cases
        step("R6 R7 word add to signed overflow", 16'h7FFF, 16'h0001, 3'd0, 1'b0, 1'b1, 3'd0);
        step("R5 R7 R8 word carry to zero", 16'hFFFF, 16'h0001, 3'd0, 1'b0, 1'b1, 3'd0);
        step("R2 adc uses stored carry", 16'h1000, 16'h0001, 3'd1, 1'b0, 1'b1, 3'd0);
        step("R4 R6 byte sub overflow", 16'hAB80, 16'h0001, 3'd2, 1'b1, 1'b1, 3'd0);
        step("R5 R8 byte borrow", 16'h0010, 16'h0011, 3'd2, 1'b1, 1'b1, 3'd0);
        step("R2 sbb with borrow in", 16'h0005, 16'h0005, 3'd3, 1'b0, 1'b1, 3'd0);
        step("R9 parity low byte only", 16'hFF03, 16'h0000, 3'd5, 1'b0, 1'b1, 3'd0);
        step("R3 logic clears carry", 16'hF0F0, 16'h0F0F, 3'd4, 1'b0, 1'b1, 3'd0);
        step("R5 sub sets carry", 16'h0000, 16'h0001, 3'd2, 1'b0, 1'b1, 3'd0);
        step("R3 xor after carry", 16'h8001, 16'h0001, 3'd6, 1'b0, 1'b1, 3'd0);
        step("R12 pass ignores update", 16'h1234, 16'h0001, 3'd7, 1'b1, 1'b1, 3'd0);
        step("R10 no update holds", 16'hFFFF, 16'hFFFF, 3'd0, 1'b0, 1'b0, 3'd0);
        step("R11 set dir with update", 16'h0001, 16'h0001, 3'd2, 1'b0, 1'b1, 3'd2);
        step("R11 set int", 16'h0000, 16'h0000, 3'd0, 1'b0, 1'b0, 3'd4);
        step("R11 set trap with update", 16'h00FF, 16'h0001, 3'd0, 1'b1, 1'b1, 3'd6);
        step("R11 clear dir", 16'h0000, 16'h0000, 3'd0, 1'b0, 1'b0, 3'd1);
        step("R11 clear int with update", 16'h8000, 16'h8000, 3'd0, 1'b0, 1'b1, 3'd3);
        step("R11 clear trap", 16'h0000, 16'h0000, 3'd0, 1'b0, 1'b0, 3'd5);
        step("R11 R13 idle code 7", 16'h0000, 16'h0000, 3'd0, 1'b0, 1'b0, 3'd7);

        // constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [15:0] ra, rb;
            ra = 16'($urandom);
            rb = 16'($urandom);
            if ((i % 7) == 0) rb = ra;
            if ((i % 11) == 0) ra = 16'h7FFF;
            step("R2 R4 R5 R6 R7 R8 R9 R10 R11 R13 random", ra, rb, 3'($urandom),
                 1'($urandom), ($urandom % 4) != 0, 3'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule